// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the interrupt pathway of a small 16-bit processor. It watches three request sources: a level-sensitive maskable line, an edge-sensitive non-maskable line, and a software-interrupt request from the decoder that carries an 8-bit vector number. A fourth input, the return request, starts the sequence that ends a handler. When the block is idle it accepts at most one request. It then saves the processor state to a stack through a word-wide memory port, clears the enable and trap flags, and fetches the new code segment and instruction pointer from a vector table held at segment zero.

On a return the block pops the saved instruction pointer, code segment and flags in the reverse order of the pushes. This brings both the enable flag and the trap flag back to their values before entry. The processor supplies its current FLAGS, CS, IP, SS and SP on inputs. When a sequence completes, the block presents the updated values together with a one-cycle completion pulse, and the processor loads them on that pulse.

Top module: `intr_sequencer`

## Requirements
- R1: A maskable request is accepted only while bit 9 of `cur_flags` (mask 0x0200, the interrupt-enable flag) is 1. While that bit is 0 the request is ignored: `irq_ack` stays low and `busy` stays low.
- R2: A rising edge on `nmi_in` is latched and serviced whatever bit 9 of `cur_flags` holds, using fixed vector 2.
- R3: A software request (`sw_req` with `sw_vec`) is always executed, even when bit 9 of `cur_flags` is 0.
- R4: When requests coincide in an idle cycle, the order of priority is: software request, then return request, then the latched non-maskable request, then the enabled maskable request. A request that loses stays pending if it is latched or held.
- R5: Entry writes three words in this order: the original FLAGS at SS:SP-2, CS at SS:SP-4 and IP at SS:SP-6. The new SP is SP-6. The physical address is SEG*16+OFFSET, taken modulo 2^20, and each offset wraps within 16 bits.
- R6: After entry, `out_flags` equals the original FLAGS with bit 9 (IF) and bit 8 (TF) cleared. The pushed FLAGS word keeps both bits.
- R7: For vector n, the new IP is read from physical address n*4 and the new CS from n*4+2, both in that order. For example, vector 0x60 reads 0x180 and then 0x182.
- R8: For an accepted maskable request, `irq_ack` is high for exactly one cycle, in the cycle after acceptance. The vector on `irq_vec` is sampled in that same cycle.
- R9: A return reads IP from SS:SP, then CS from SS:SP+2, then FLAGS from SS:SP+4. The new SP is SP+6, so IF and TF come back to their values before entry.
- R10: `busy` is high from the cycle after acceptance through the completion cycle. `done` is a one-cycle pulse at the end of both the entry and the return sequences, and `busy` is low in the cycle after `done`.
- R11: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until a one-cycle `mem_ack`. Any number of wait states is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lvl | input | 1 | Maskable request, level-sensitive |
| irq_vec | input | 8 | Vector number for the maskable request, valid while `irq_ack` is high |
| irq_ack | output | 1 | Vector acknowledge strobe to the interrupt controller |
| nmi_in | input | 1 | Non-maskable request, edge-sensitive |
| sw_req | input | 1 | Software interrupt request from decode |
| sw_vec | input | 8 | Software interrupt vector number |
| ret_req | input | 1 | Interrupt return request from decode |
| cur_flags | input | 16 | Current FLAGS |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Current instruction pointer |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| out_flags | output | 16 | FLAGS after the sequence, valid with `done` |
| out_cs | output | 16 | CS after the sequence, valid with `done` |
| out_ip | output | 16 | IP after the sequence, valid with `done` |
| out_sp | output | 16 | SP after the sequence, valid with `done` |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a stack write, 0 for a read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle access completion |

## Verification
The bench builds the block with its default parameters: a 20-bit physical address, a segment shift of 4, 16-bit words and non-maskable vector 2. Random stack segments up to 0xFFFF and random odd or small stack pointers drive the segment-plus-offset sum past 2^20. They also drive the offset subtraction below zero, so both wrap paths are reached. The memory model inserts 0 to 3 random wait states per access, which keeps each request held across stalls. A directed case raises all three request sources in one cycle, so that the latched non-maskable request is then serviced while the maskable line stays masked by the flags that the first entry cleared.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_IACK,
    S_PUSH_F,
    S_PUSH_CS,
    S_PUSH_IP,
    S_RD_IP,
    S_RD_CS,
    S_POP_IP,
    S_POP_CS,
    S_POP_F,
    S_DONE
  } seq_state_e;

  // Grant vector positions, lowest index wins
  localparam int GNT_SW  = 0;
  localparam int GNT_RET = 1;
  localparam int GNT_NMI = 2;
  localparam int GNT_IRQ = 3;
  localparam int GNT_N   = 4;
endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int IF_BIT = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              sw_req,
  input  logic              ret_req,
  input  logic              nmi_in,
  input  logic              irq_lvl,
  input  logic [DATA_W-1:0] cur_flags,
  output logic [GNT_N-1:0]  grant
);
  logic nmi_q, nmi_d;
  logic pend_q, pend_d;
  logic nmi_rise;
  logic [GNT_N-1:0] req;

  assign nmi_rise = nmi_in & ~nmi_q;

  always_comb begin
    req          = '0;
    req[GNT_SW]  = sw_req;
    req[GNT_RET] = ret_req;
    req[GNT_NMI] = pend_q;
    req[GNT_IRQ] = irq_lvl & cur_flags[IF_BIT];
    req          = req & {GNT_N{idle}};
    grant        = req & (~req + GNT_N'(1));
  end

  always_comb begin
    nmi_d  = nmi_in;
    pend_d = nmi_rise | (pend_q & ~grant[GNT_NMI]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_d;
      pend_q <= pend_d;
    end
  end

  // R4: a single source is granted at a time
  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2: an edge seen while busy stays latched
  assert_nmi_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_rise && !idle) |=> pend_q);
endmodule

// File: rtl/intr_addr_gen.sv
module intr_addr_gen
  import intr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  seq_state_e        state,
  input  logic [DATA_W-1:0] ss,
  input  logic [DATA_W-1:0] sp,
  input  logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(2);

  logic [DATA_W-1:0] seg, off, vbase;

  assign vbase = DATA_W'({vec, 2'b00});

  always_comb begin
    seg = '0;
    off = '0;
    unique case (state)
      S_PUSH_F, S_PUSH_CS, S_PUSH_IP: begin
        seg = ss;
        off = sp - STEP;
      end
      S_POP_IP, S_POP_CS, S_POP_F: begin
        seg = ss;
        off = sp;
      end
      S_RD_IP: off = vbase;
      S_RD_CS: off = vbase + STEP;
      default: begin
        seg = '0;
        off = '0;
      end
    endcase
    addr = ADDR_W'({seg, {SEG_SHIFT{1'b0}}}) + ADDR_W'(off);
  end
endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
  import intr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int VEC_W   = 8,
  parameter int IF_BIT  = 9,
  parameter int TF_BIT  = 8,
  parameter int NMI_VEC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GNT_N-1:0]  grant,
  input  logic [VEC_W-1:0]  sw_vec,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic [DATA_W-1:0] cur_flags,
  input  logic [DATA_W-1:0] cur_cs,
  input  logic [DATA_W-1:0] cur_ip,
  input  logic [DATA_W-1:0] cur_ss,
  input  logic [DATA_W-1:0] cur_sp,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output seq_state_e        state,
  output logic [DATA_W-1:0] ss_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [DATA_W-1:0] flags_o,
  output logic [DATA_W-1:0] cs_o,
  output logic [DATA_W-1:0] ip_o,
  output logic              irq_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  localparam logic [DATA_W-1:0] STEP     = DATA_W'(2);
  localparam logic [DATA_W-1:0] CLR_MASK = (DATA_W'(1) << IF_BIT) | (DATA_W'(1) << TF_BIT);

  seq_state_e        state_q, state_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [DATA_W-1:0] flags_q, flags_d, cs_q, cs_d, ip_q, ip_d;
  logic [DATA_W-1:0] sp_q, sp_d, ss_q, ss_d;
  logic              snap_en;

  assign snap_en = |grant;

  always_comb begin
    state_d   = state_q;
    vec_d     = vec_q;
    flags_d   = flags_q;
    cs_d      = cs_q;
    ip_d      = ip_q;
    sp_d      = sp_q;
    ss_d      = ss_q;
    irq_ack   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      S_IDLE: begin
        if (snap_en) begin
          flags_d = cur_flags;
          cs_d    = cur_cs;
          ip_d    = cur_ip;
          sp_d    = cur_sp;
          ss_d    = cur_ss;
          if (grant[GNT_SW]) begin
            vec_d   = sw_vec;
            state_d = S_PUSH_F;
          end else if (grant[GNT_RET]) begin
            state_d = S_POP_IP;
          end else if (grant[GNT_NMI]) begin
            vec_d   = VEC_W'(NMI_VEC);
            state_d = S_PUSH_F;
          end else begin
            state_d = S_IACK;
          end
        end
      end
      S_IACK: begin
        irq_ack = 1'b1;
        vec_d   = irq_vec;
        state_d = S_PUSH_F;
      end
      S_PUSH_F: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = flags_q;
        if (mem_ack) begin
          sp_d    = sp_q - STEP;
          flags_d = flags_q & ~CLR_MASK;
          state_d = S_PUSH_CS;
        end
      end
      S_PUSH_CS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = cs_q;
        if (mem_ack) begin
          sp_d    = sp_q - STEP;
          state_d = S_PUSH_IP;
        end
      end
      S_PUSH_IP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = ip_q;
        if (mem_ack) begin
          sp_d    = sp_q - STEP;
          state_d = S_RD_IP;
        end
      end
      S_RD_IP: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ip_d    = mem_rdata;
          state_d = S_RD_CS;
        end
      end
      S_RD_CS: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          cs_d    = mem_rdata;
          state_d = S_DONE;
        end
      end
      S_POP_IP: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ip_d    = mem_rdata;
          sp_d    = sp_q + STEP;
          state_d = S_POP_CS;
        end
      end
      S_POP_CS: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          cs_d    = mem_rdata;
          sp_d    = sp_q + STEP;
          state_d = S_POP_F;
        end
      end
      S_POP_F: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          flags_d = mem_rdata;
          sp_d    = sp_q + STEP;
          state_d = S_DONE;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      vec_q   <= '0;
      flags_q <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      sp_q    <= '0;
      ss_q    <= '0;
    end else begin
      state_q <= state_d;
      vec_q   <= vec_d;
      flags_q <= flags_d;
      cs_q    <= cs_d;
      ip_q    <= ip_d;
      sp_q    <= sp_d;
      ss_q    <= ss_d;
    end
  end

  assign state   = state_q;
  assign ss_o    = ss_q;
  assign sp_o    = sp_q;
  assign vec_o   = vec_q;
  assign flags_o = flags_q;
  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign busy    = (state_q != S_IDLE);
  assign done    = (state_q == S_DONE);

  // R1: the acknowledge follows an acceptance made with interrupts enabled
  assert_ack_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(cur_flags[IF_BIT]));

  // R6: once FLAGS is pushed, IF and TF are already clear
  assert_flags_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUSH_CS) |-> (!flags_q[IF_BIT] && !flags_q[TF_BIT]));

  // R10: busy drops right after the completion pulse
  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10: completion only follows a finished memory access
  assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_ack));
endmodule

// File: rtl/intr_sequencer.sv
module intr_sequencer
  import intr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int NMI_VEC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_lvl,
  input  logic [VEC_W-1:0]  irq_vec,
  output logic              irq_ack,
  input  logic              nmi_in,
  input  logic              sw_req,
  input  logic [VEC_W-1:0]  sw_vec,
  input  logic              ret_req,
  input  logic [DATA_W-1:0] cur_flags,
  input  logic [DATA_W-1:0] cur_cs,
  input  logic [DATA_W-1:0] cur_ip,
  input  logic [DATA_W-1:0] cur_ss,
  input  logic [DATA_W-1:0] cur_sp,
  output logic [DATA_W-1:0] out_flags,
  output logic [DATA_W-1:0] out_cs,
  output logic [DATA_W-1:0] out_ip,
  output logic [DATA_W-1:0] out_sp,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [GNT_N-1:0]  grant;
  seq_state_e        state;
  logic [DATA_W-1:0] ss_w;
  logic [VEC_W-1:0]  vec_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  intr_arbiter #(.IF_BIT(IF_BIT), .DATA_W(DATA_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .idle      (state == S_IDLE),
    .sw_req    (sw_req),
    .ret_req   (ret_req),
    .nmi_in    (nmi_in),
    .irq_lvl   (irq_lvl),
    .cur_flags (cur_flags),
    .grant     (grant)
  );

  intr_seq_fsm #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .IF_BIT(IF_BIT),
    .TF_BIT(TF_BIT), .NMI_VEC(NMI_VEC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .grant     (grant),
    .sw_vec    (sw_vec),
    .irq_vec   (irq_vec),
    .cur_flags (cur_flags),
    .cur_cs    (cur_cs),
    .cur_ip    (cur_ip),
    .cur_ss    (cur_ss),
    .cur_sp    (cur_sp),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .state     (state),
    .ss_o      (ss_w),
    .sp_o      (out_sp),
    .vec_o     (vec_w),
    .flags_o   (out_flags),
    .cs_o      (out_cs),
    .ip_o      (out_ip),
    .irq_ack   (irq_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done)
  );

  intr_addr_gen #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)
  ) u_addr (
    .state (state),
    .ss    (ss_w),
    .sp    (out_sp),
    .vec   (vec_w),
    .addr  (mem_addr)
  );

  // R11: a pending access holds its request, address and data
  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
endmodule

// File: tb/intr_sequencer_tb.sv
module intr_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_lvl, nmi_in, sw_req, ret_req, irq_ack;
  logic [7:0]  irq_vec, sw_vec;
  logic [15:0] a_flags, a_cs, a_ip, a_ss, a_sp;
  logic [15:0] out_flags, out_cs, out_ip, out_sp;
  logic        busy, done, mem_req, mem_we, mem_ack;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [logic [19:0]];
  logic [19:0] wlog [3];
  logic [19:0] rlog [3];
  int wn, rn, wait_cnt, cyc;
  int n_chk = 0, n_fail = 0;
  logic [15:0] p_flags, p_cs, p_ip, p_ss, p_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .nmi_in(nmi_in), .sw_req(sw_req), .sw_vec(sw_vec), .ret_req(ret_req),
    .cur_flags(a_flags), .cur_cs(a_cs), .cur_ip(a_ip), .cur_ss(a_ss), .cur_sp(a_sp),
    .out_flags(out_flags), .out_cs(out_cs), .out_ip(out_ip), .out_sp(out_sp),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({4'b0, s} << 4) + {4'b0, o};
  endfunction

  function automatic logic [15:0] rd(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // memory model with random wait states (R11)
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          if (wn < 3) wlog[wn] = mem_addr;
          wn++;
        end else begin
          mem_rdata = rd(mem_addr);
          if (rn < 3) rlog[rn] = mem_addr;
          rn++;
        end
        wait_cnt = $urandom_range(0, 3);
      end else wait_cnt--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic snap();
    p_flags = a_flags; p_cs = a_cs; p_ip = a_ip; p_ss = a_ss; p_sp = a_sp;
    wn = 0; rn = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check(1'b0, "R10 done timeout", 0, 1);
  endtask

  task automatic finish_entry(input logic [7:0] v);
    logic [15:0] vb, eip, ecs, ef;
    vb  = {6'b0, v, 2'b00};
    wait_done();
    eip = rd(phys(16'h0, vb));
    ecs = rd(phys(16'h0, vb + 16'd2));
    ef  = p_flags & ~16'h0300;
    check(out_ip == eip, "R7 new IP", out_ip, eip);
    check(out_cs == ecs, "R7 new CS", out_cs, ecs);
    check(out_flags == ef, "R6 flags cleared", out_flags, ef);
    check(out_sp == p_sp - 16'd6, "R5 sp after entry", out_sp, p_sp - 16'd6);
    check(rd(phys(p_ss, p_sp - 16'd2)) == p_flags, "R5 pushed FLAGS R6",
          rd(phys(p_ss, p_sp - 16'd2)), p_flags);
    check(rd(phys(p_ss, p_sp - 16'd4)) == p_cs, "R5 pushed CS",
          rd(phys(p_ss, p_sp - 16'd4)), p_cs);
    check(rd(phys(p_ss, p_sp - 16'd6)) == p_ip, "R5 pushed IP",
          rd(phys(p_ss, p_sp - 16'd6)), p_ip);
    check(wn == 3 && wlog[0] == phys(p_ss, p_sp - 16'd2) && wlog[1] == phys(p_ss, p_sp - 16'd4)
          && wlog[2] == phys(p_ss, p_sp - 16'd6), "R5 push order", wlog[0], phys(p_ss, p_sp - 16'd2));
    check(rn == 2 && rlog[0] == phys(16'h0, vb) && rlog[1] == phys(16'h0, vb + 16'd2),
          "R7 vector read order", rlog[0], phys(16'h0, vb));
    a_flags = ef; a_cs = ecs; a_ip = eip; a_sp = p_sp - 16'd6;
    @(negedge clk);
    check(!busy && !done, "R10 busy and done drop", {busy, done}, 0);
  endtask

  task automatic do_return();
    logic [15:0] eip, ecs, ef;
    snap();
    eip = rd(phys(p_ss, p_sp));
    ecs = rd(phys(p_ss, p_sp + 16'd2));
    ef  = rd(phys(p_ss, p_sp + 16'd4));
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done();
    check(out_ip == eip, "R9 popped IP", out_ip, eip);
    check(out_cs == ecs, "R9 popped CS", out_cs, ecs);
    check(out_flags == ef, "R9 popped FLAGS", out_flags, ef);
    check(out_sp == p_sp + 16'd6, "R9 sp after return", out_sp, p_sp + 16'd6);
    check(rn == 3 && wn == 0 && rlog[0] == phys(p_ss, p_sp) && rlog[2] == phys(p_ss, p_sp + 16'd4),
          "R9 pop order", rlog[0], phys(p_ss, p_sp));
    a_flags = ef; a_cs = ecs; a_ip = eip; a_sp = p_sp + 16'd6;
    @(negedge clk);
  endtask

  task automatic set_vec(input logic [7:0] v);
    logic [15:0] vb;
    vb = {6'b0, v, 2'b00};
    mem[phys(16'h0, vb)]         = 16'($urandom);
    mem[phys(16'h0, vb + 16'd2)] = 16'($urandom);
  endtask

  task automatic entry_sw(input logic [7:0] v);
    snap();
    sw_vec = v; sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    finish_entry(v);
  endtask

  task automatic entry_nmi();
    snap();
    nmi_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    nmi_in = 1'b0;
    finish_entry(8'd2);
  endtask

  task automatic entry_irq(input logic [7:0] v);
    int k;
    snap();
    irq_vec = ~v; irq_lvl = 1'b1;
    k = 0;
    while (!irq_ack && k < 50) begin
      @(negedge clk);
      k++;
    end
    check(irq_ack == 1'b1, "R8 irq_ack seen", irq_ack, 1);
    irq_vec = v; irq_lvl = 1'b0;
    @(negedge clk);
    irq_vec = ~v;
    check(irq_ack == 1'b0 && busy, "R8 ack one cycle", {irq_ack, busy}, 1);
    finish_entry(v);
  endtask

  initial begin
    logic [7:0] v;
    bit seen;
    void'($urandom(32'd4217));
    rst_n = 1'b0; irq_lvl = 0; nmi_in = 0; sw_req = 0; ret_req = 0;
    irq_vec = 0; sw_vec = 0; mem_ack = 0; mem_rdata = 0; wait_cnt = 0; cyc = 0;
    a_flags = 16'h0000; a_cs = 16'h1000; a_ip = 16'h0100; a_ss = 16'h2000; a_sp = 16'h0400;
    wn = 0; rn = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !irq_ack, "R10 reset state",
          {busy, done, mem_req, irq_ack}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: masked maskable request is ignored
    a_flags = 16'hFDFF;
    irq_lvl = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || irq_ack || mem_req) seen = 1;
    end
    irq_lvl = 1'b0;
    check(!seen, "R1 masked request ignored", seen, 0);

    // R3/R7: software vector 0x60 with IF clear
    a_flags = 16'h0100;
    set_vec(8'h60);
    entry_sw(8'h60);
    check(rlog[0] == 20'h00180 && rlog[1] == 20'h00182, "R7 vector 0x60 addresses R3",
          rlog[0], 20'h00180);
    do_return();
    check(a_flags == 16'h0100, "R9 IF stays clear after return", a_flags, 16'h0100);

    // R2: non-maskable with IF clear uses vector 2
    set_vec(8'd2);
    entry_nmi();
    do_return();

    // R4: all three at once with IF set
    a_flags = 16'h0200 | 16'h0100;
    set_vec(8'h21);
    snap();
    sw_vec = 8'h21; sw_req = 1'b1; nmi_in = 1'b1; irq_lvl = 1'b1; irq_vec = 8'h33;
    @(negedge clk);
    sw_req = 1'b0; nmi_in = 1'b0;
    finish_entry(8'h21);
    snap();
    finish_entry(8'd2);
    check(!irq_ack, "R4 maskable waits behind latched NMI", irq_ack, 0);
    irq_lvl = 1'b0;
    do_return();
    do_return();
    check(a_flags == 16'h0300, "R9 IF and TF restored", a_flags, 16'h0300);

    // Random mix with wrap-prone segments and pointers
    for (int it = 0; it < 40; it++) begin
      int kind;
      kind = $urandom_range(0, 2);
      v = 8'($urandom);
      a_flags = 16'($urandom);
      a_cs = 16'($urandom); a_ip = 16'($urandom);
      a_ss = ($urandom_range(0, 1) == 1) ? 16'hFFF0 | 16'($urandom_range(0, 15)) : 16'($urandom);
      a_sp = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 4)) : 16'($urandom);
      if (kind == 1) v = 8'd2;
      set_vec(v);
      if (kind == 0) entry_sw(v);
      else if (kind == 1) entry_nmi();
      else begin
        a_flags = a_flags | 16'h0200;
        entry_irq(v);
      end
      do_return();
    end

    finish_run();
  end
endmodule